// File: doc/BRIEF.md
# Host Memory Access Arbiter for a TDM Switch

This block lets an 8-bit asynchronous host bus read and write two memories inside a time-division switch: the switching data store and the virtual channel store. The switching engine owns the memory ports. It reports each cycle in which it needs them on a busy line, and a host access is fitted into the first cycle the engine leaves free. The host therefore sees a wait of no fixed length. That wait depends on how much memory bandwidth the programmed connections take.

The host side supports two handshake styles, chosen by a style input that is sampled while reset is high. In ready style, a ready line drops as soon as an access starts and rises again when the memory transaction is done. In acknowledge style, an active-low acknowledge asserts when the transaction is done and releases after the host removes its strobe. Address and write data are captured when the strobe first asserts. The memory transaction uses those captured values, so the host need not hold them.

The virtual channel store can only be reached after a diagnostic enable is set. While the enable is clear, an access to that region completes at once: a read returns zero and a write is dropped. When no virtual channel connections are programmed, the engine never uses that store, and accesses to it complete without waiting for a free slot.

Top module: `hostmem_arbiter`

## Requirements
- R1: While reset is high and on the cycle after it falls, host_rdy is 1, host_dtack_n is 1, host_doe is 0 and mem_en is 0.
- R2: mem_en is never 1 in a cycle where eng_busy is 1, unless the access targets the virtual channel region (host_addr MSB = 1) and vc_idle is 1.
- R3: A pending host access drives mem_en in the first cycle eng_busy is 0. mem_en is combinational from eng_busy in that cycle.
- R4: In ready style (bus_style_i = 0 at reset), host_rdy is 0 from the cycle the strobe asserts until the access completes. It is 1 once the access completes. host_dtack_n stays 1.
- R5: In acknowledge style (bus_style_i = 1 at reset), host_dtack_n is 1 while the access waits and goes to 0 when it completes. It returns to 1 on the cycle after the strobe is removed. host_rdy stays 1.
- R6: With vc_diag_en = 0, an access to the virtual channel region (host_addr MSB = 1) issues no mem_en. A read returns 0x00 and a write leaves the memory unchanged.
- R7: With vc_idle = 1, an enabled virtual channel access is serviced even while eng_busy is 1. With vc_idle = 0, it waits for eng_busy = 0.
- R8: host_doe is 1 only while a read strobe is active (host_cs_n = 0 and host_rd_n = 0). It is 0 during writes and when no strobe is active.
- R9: mem_addr and mem_wdata of a write carry the address and data present when the strobe asserted, even if host_addr or host_din change later.
- R10: The handshake style is fixed at reset. Changing bus_style_i after reset has no effect.
- R11: Read data is taken from mem_rdata one cycle after the mem_en read cycle and is shown on host_dout when the access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_style_i | input | 1 | Handshake style at reset: 0 ready, 1 acknowledge |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Ready style: read strobe. Acknowledge style: data strobe |
| host_wr_n | input | 1 | Ready style: write strobe. Acknowledge style: read/write, 1 = read |
| host_addr | input | ADDR_W | Host address; MSB selects the virtual channel region |
| host_din | input | DATA_W | Write data from the host |
| host_dout | output | DATA_W | Read data to the host |
| host_doe | output | 1 | Output enable for the host data pads |
| host_rdy | output | 1 | Ready line, low while an access is in progress |
| host_dtack_n | output | 1 | Transfer acknowledge, active low |
| eng_busy | input | 1 | Switch engine uses the memories this cycle |
| vc_diag_en | input | 1 | Diagnostic enable for the virtual channel region |
| vc_idle | input | 1 | No virtual channel connections are programmed |
| mem_en | output | 1 | Host memory transaction this cycle |
| mem_we | output | 1 | Transaction is a write |
| mem_vc | output | 1 | Transaction targets the virtual channel store |
| mem_addr | output | ADDR_W-1 | Word offset inside the selected store |
| mem_wdata | output | DATA_W | Write data to memory |
| mem_rdata | input | DATA_W | Read data, valid one cycle after a read transaction |

## Verification
The hardest case to reach is an access that sits pending while the engine holds the memory for a chosen number of cycles. The host address and data must change during that wait, and the grant must land exactly on the first free cycle. The stimulus keeps the strobe asserted and holds eng_busy high for a set count. It alters host_addr and host_din partway through, then drops eng_busy on a known falling edge and samples mem_en, mem_addr and mem_wdata in that same cycle. The gated region is driven through a write, a gated write and a re-enabled read. This shows the dropped write left the stored value intact.

// File: rtl/hostmem_pkg.sv
package hostmem_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_WAIT = 2'd1,
        ACC_RCAP = 2'd2,
        ACC_DONE = 2'd3
    } acc_state_e;

    typedef enum logic {
        STYLE_READY = 1'b0,
        STYLE_ACK   = 1'b1
    } bus_style_e;

    typedef struct packed {
        logic active;
        logic read;
    } strobe_t;

    function automatic strobe_t decode_strobe(bus_style_e style, logic cs_n,
                                              logic rd_n, logic wr_n);
        strobe_t s;
        if (style == STYLE_READY) begin
            s.active = !cs_n && (!rd_n || !wr_n);
            s.read   = !rd_n;
        end else begin
            s.active = !cs_n && !rd_n;
            s.read   = wr_n;
        end
        return s;
    endfunction

endpackage

// File: rtl/hostmem_strobe_dec.sv
module hostmem_strobe_dec
    import hostmem_pkg::*;
(
    input  bus_style_e style,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    output strobe_t    stb
);
    always_comb stb = decode_strobe(style, cs_n, rd_n, wr_n);
endmodule

// File: rtl/hostmem_slot_grant.sv
module hostmem_slot_grant (
    input  logic pending,
    input  logic target_vc,
    input  logic eng_busy,
    input  logic vc_idle,
    output logic grant
);
    logic slot_free;

    // The engine leaves the virtual channel store alone when it has no such connections
    always_comb begin
        slot_free = !eng_busy || (target_vc && vc_idle);
        grant     = pending && slot_free;
    end
endmodule

// File: rtl/hostmem_seq.sv
module hostmem_seq
    import hostmem_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    localparam int OFS_W = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              vc_diag_en,
    input  logic              grant,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              pending,
    output logic              req_vc,
    output logic              done,
    output logic              mem_en,
    output logic              mem_we,
    output logic [OFS_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] rdata
);
    acc_state_e        state;
    logic              req_read;
    logic [OFS_W-1:0]  req_ofs;
    logic [DATA_W-1:0] req_wdata;
    logic              hit_vc;

    assign hit_vc = addr[ADDR_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ACC_IDLE;
            req_read  <= 1'b0;
            req_vc    <= 1'b0;
            req_ofs   <= '0;
            req_wdata <= '0;
            rdata     <= '0;
        end else begin
            unique case (state)
                ACC_IDLE: if (stb.active) begin
                    req_read  <= stb.read;
                    req_vc    <= hit_vc;
                    req_ofs   <= addr[OFS_W-1:0];
                    req_wdata <= din;
                    if (hit_vc && !vc_diag_en) begin
                        rdata <= '0;
                        state <= ACC_DONE;
                    end else begin
                        state <= ACC_WAIT;
                    end
                end
                ACC_WAIT: if (grant) state <= req_read ? ACC_RCAP : ACC_DONE;
                ACC_RCAP: begin
                    rdata <= mem_rdata;
                    state <= ACC_DONE;
                end
                ACC_DONE: if (!stb.active) state <= ACC_IDLE;
                default:  state <= ACC_IDLE;
            endcase
        end
    end

    always_comb begin
        pending   = (state == ACC_WAIT);
        done      = (state == ACC_DONE);
        mem_en    = pending && grant;
        mem_we    = !req_read;
        mem_addr  = req_ofs;
        mem_wdata = req_wdata;
    end
endmodule

// File: rtl/hostmem_arbiter.sv
module hostmem_arbiter
    import hostmem_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    localparam int OFS_W = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_style_i,
    input  logic              host_cs_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic              host_doe,
    output logic              host_rdy,
    output logic              host_dtack_n,
    input  logic              eng_busy,
    input  logic              vc_diag_en,
    input  logic              vc_idle,
    output logic              mem_en,
    output logic              mem_we,
    output logic              mem_vc,
    output logic [OFS_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    bus_style_e style_q;
    strobe_t    stb;
    logic       pending;
    logic       grant;
    logic       done;
    logic       req_vc;

    always_ff @(posedge clk) begin
        if (rst) style_q <= bus_style_e'(bus_style_i);
    end

    hostmem_strobe_dec u_dec (
        .style (style_q),
        .cs_n  (host_cs_n),
        .rd_n  (host_rd_n),
        .wr_n  (host_wr_n),
        .stb   (stb)
    );

    hostmem_slot_grant u_grant (
        .pending   (pending),
        .target_vc (req_vc),
        .eng_busy  (eng_busy),
        .vc_idle   (vc_idle),
        .grant     (grant)
    );

    hostmem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .stb        (stb),
        .addr       (host_addr),
        .din        (host_din),
        .vc_diag_en (vc_diag_en),
        .grant      (grant),
        .mem_rdata  (mem_rdata),
        .pending    (pending),
        .req_vc     (req_vc),
        .done       (done),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .rdata      (host_dout)
    );

    always_comb begin
        mem_vc       = req_vc;
        host_doe     = !rst && stb.active && stb.read;
        host_rdy     = rst || (style_q != STYLE_READY) || !(stb.active && !done);
        host_dtack_n = rst || !((style_q == STYLE_ACK) && done);
    end
endmodule

// File: rtl/hostmem_arbiter_chk.sv
module hostmem_arbiter_chk #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input logic clk,
    input logic rst,
    input logic host_cs_n,
    input logic host_rd_n,
    input logic host_doe,
    input logic host_rdy,
    input logic host_dtack_n,
    input logic eng_busy,
    input logic vc_diag_en,
    input logic vc_idle,
    input logic mem_en,
    input logic mem_vc
);
    // R2
    engine_first_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !(mem_vc && vc_idle)) |-> !eng_busy);

    // R6
    vc_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_vc) |-> vc_diag_en);

    // R8
    doe_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        host_doe |-> (!host_cs_n && !host_rd_n));

    // R5
    dtack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!host_dtack_n && (host_cs_n || host_rd_n)) |=> host_dtack_n);

    // R4
    single_handshake_chk: assert property (@(posedge clk) disable iff (rst)
        !host_dtack_n |-> host_rdy);
endmodule

bind hostmem_arbiter hostmem_arbiter_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_cs_n    (host_cs_n),
    .host_rd_n    (host_rd_n),
    .host_doe     (host_doe),
    .host_rdy     (host_rdy),
    .host_dtack_n (host_dtack_n),
    .eng_busy     (eng_busy),
    .vc_diag_en   (vc_diag_en),
    .vc_idle      (vc_idle),
    .mem_en       (mem_en),
    .mem_vc       (mem_vc)
);

// File: tb/tb_hostmem_arbiter.sv
`timescale 1ns/1ps
module tb_hostmem_arbiter;
    localparam int AW = 5;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_style_i = 1'b0;
    logic          host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_din = '0;
    logic [DW-1:0] host_dout;
    logic          host_doe, host_rdy, host_dtack_n;
    logic          eng_busy = 1'b0, vc_diag_en = 1'b0, vc_idle = 1'b0;
    logic          mem_en, mem_we, mem_vc;
    logic [AW-2:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;

    int checks = 0;
    int errors = 0;
    int en_count = 0;
    int cycles = 0;
    bit ack_style = 1'b0;

    always #4 clk = ~clk;

    hostmem_arbiter #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

    logic [DW-1:0] store [0:(1<<AW)-1];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < (1 << AW); i++) store[i] <= '0;
            mem_rdata <= '0;
        end else if (mem_en) begin
            if (mem_we) store[{mem_vc, mem_addr}] <= mem_wdata;
            mem_rdata <= store[{mem_vc, mem_addr}];
            en_count  <= en_count + 1;
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected under 50000", cycles);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit style);
        @(negedge clk);
        rst = 1'b1; bus_style_i = style; ack_style = style;
        host_cs_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(host_rdy && host_dtack_n && !host_doe && !mem_en, "R1 in reset",
            {host_rdy, host_dtack_n, host_doe, mem_en}, 4'b1100);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(host_rdy && host_dtack_n && !host_doe && !mem_en, "R1 after reset",
            {host_rdy, host_dtack_n, host_doe, mem_en}, 4'b1100);
    endtask

    task automatic start_strobe(input bit rd, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        host_addr = a; host_din = d; host_cs_n = 1'b0;
        if (!ack_style) begin host_rd_n = !rd; host_wr_n = rd; end
        else begin host_rd_n = 1'b0; host_wr_n = rd; end
    endtask

    task automatic end_strobe();
        @(negedge clk);
        host_cs_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1;
    endtask

    function automatic bit is_done();
        return ack_style ? !host_dtack_n : host_rdy;
    endfunction

    task automatic wait_done(output bit ok, output logic [DW-1:0] rd);
        ok = 1'b0; rd = '0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); #1;
            if (is_done()) begin ok = 1'b1; rd = host_dout; break; end
        end
    endtask

    task automatic host_access(input bit rdop, input logic [AW-1:0] a,
                               input logic [DW-1:0] d, output logic [DW-1:0] rd);
        bit ok;
        start_strobe(rdop, a, d);
        wait_done(ok, rd);
        chk(ok, "R4/R5 completion", ok, 1);
        end_strobe();
        @(negedge clk);
    endtask

    task automatic t_basic_rw();
        logic [DW-1:0] r;
        host_access(1'b0, 5'h05, 8'h5A, r);
        chk(store[5'h05] == 8'h5A, "R11 write stored", store[5'h05], 8'h5A);
        host_access(1'b1, 5'h05, 8'h00, r);
        chk(r == 8'h5A, "R11 read data", r, 8'h5A);
        host_access(1'b0, 5'h09, 8'hC3, r);
        host_access(1'b1, 5'h09, 8'h00, r);
        chk(r == 8'hC3, "R11 second pattern", r, 8'hC3);
    endtask

    task automatic t_busy_wait();
        bit ok; logic [DW-1:0] r;
        eng_busy = 1'b1;
        start_strobe(1'b1, 5'h05, 8'h00);
        #1;
        chk(!host_rdy, "R4 rdy drops at strobe", host_rdy, 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); #1;
            chk(!mem_en, "R2 no grant while busy", mem_en, 0);
            chk(!host_rdy && host_dtack_n, "R4 rdy low while waiting", {host_rdy, host_dtack_n}, 2'b01);
        end
        @(negedge clk); eng_busy = 1'b0; #1;
        chk(mem_en, "R3 grant on first free cycle", mem_en, 1);
        wait_done(ok, r);
        chk(ok && r == 8'h5A, "R4 completes with data", r, 8'h5A);
        chk(host_rdy, "R4 rdy high at completion", host_rdy, 1);
        end_strobe(); @(negedge clk);
    endtask

    task automatic t_latch();
        bit ok; logic [DW-1:0] r;
        eng_busy = 1'b1;
        start_strobe(1'b0, 5'h07, 8'h81);
        repeat (2) @(negedge clk);
        host_addr = 5'h0C; host_din = 8'h18;
        repeat (2) @(negedge clk);
        eng_busy = 1'b0; #1;
        chk(mem_en && mem_we, "R9 write granted", {mem_en, mem_we}, 2'b11);
        chk(mem_addr == 4'h7, "R9 latched address", mem_addr, 4'h7);
        chk(mem_wdata == 8'h81, "R9 latched data", mem_wdata, 8'h81);
        wait_done(ok, r);
        end_strobe(); @(negedge clk);
    endtask

    task automatic t_doe();
        logic [DW-1:0] r;
        #1;
        chk(!host_doe, "R8 idle doe", host_doe, 0);
        start_strobe(1'b0, 5'h02, 8'h11); #1;
        chk(!host_doe, "R8 write strobe doe", host_doe, 0);
        end_strobe(); @(negedge clk);
        start_strobe(1'b1, 5'h02, 8'h00); #1;
        chk(host_doe, "R8 read strobe doe", host_doe, 1);
        end_strobe(); #1;
        chk(!host_doe, "R8 doe off after strobe", host_doe, 0);
        @(negedge clk); @(negedge clk);
        r = '0;
    endtask

    task automatic t_vc_gate();
        logic [DW-1:0] r; int n0;
        vc_diag_en = 1'b1;
        host_access(1'b0, 5'h13, 8'h3C, r);
        vc_diag_en = 1'b0;
        n0 = en_count;
        host_access(1'b0, 5'h13, 8'hA5, r);
        host_access(1'b1, 5'h13, 8'h00, r);
        chk(r == 8'h00, "R6 gated read is zero", r, 0);
        chk(en_count == n0, "R6 no memory cycle when gated", en_count - n0, 0);
        vc_diag_en = 1'b1;
        host_access(1'b1, 5'h13, 8'h00, r);
        chk(r == 8'h3C, "R6 gated write dropped", r, 8'h3C);
    endtask

    task automatic t_vc_idle();
        bit ok; logic [DW-1:0] r;
        vc_diag_en = 1'b1; vc_idle = 1'b1; eng_busy = 1'b1;
        start_strobe(1'b1, 5'h13, 8'h00);
        repeat (4) @(negedge clk); #1;
        chk(is_done() && host_dout == 8'h3C, "R7 quiet region ignores busy", host_dout, 8'h3C);
        end_strobe(); @(negedge clk);
        vc_idle = 1'b0;
        start_strobe(1'b1, 5'h13, 8'h00);
        repeat (6) @(negedge clk); #1;
        chk(!is_done() && !mem_en, "R7 active region waits", {is_done(), mem_en}, 0);
        eng_busy = 1'b0;
        wait_done(ok, r);
        chk(ok && r == 8'h3C, "R7 served after busy clears", r, 8'h3C);
        end_strobe(); @(negedge clk);
    endtask

    task automatic t_ack_style();
        bit ok; logic [DW-1:0] r;
        host_access(1'b0, 5'h05, 8'h77, r);
        eng_busy = 1'b1;
        start_strobe(1'b1, 5'h05, 8'h00);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            chk(host_dtack_n && host_rdy, "R5 no ack while waiting", {host_dtack_n, host_rdy}, 2'b11);
        end
        eng_busy = 1'b0;
        wait_done(ok, r);
        chk(ok && r == 8'h77, "R5 ack with data", r, 8'h77);
        end_strobe(); #1;
        chk(!host_dtack_n, "R5 ack held until edge", host_dtack_n, 0);
        @(negedge clk); #1;
        chk(host_dtack_n, "R5 ack released after strobe", host_dtack_n, 1);
    endtask

    task automatic t_style_fixed();
        logic [DW-1:0] r;
        bus_style_i = 1'b0;
        host_access(1'b1, 5'h05, 8'h00, r);
        chk(r == 8'h77, "R10 style unchanged after reset", r, 8'h77);
    endtask

    initial begin
        do_reset(1'b0);
        t_basic_rw();
        t_busy_wait();
        t_latch();
        t_doe();
        t_vc_gate();
        t_vc_idle();
        do_reset(1'b1);
        t_ack_style();
        t_style_fixed();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule